// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Compare Channels

The block is a low-rate timekeeping counter clocked by a slow reference clock. A programmable divider turns that clock into tick strobes, and each tick advances a wide counter. Four sources of activity come out of it. A tick source fires on every tick. An overflow source fires when the counter wraps to zero. Up to four compare sources fire when the counter reaches a stored match value.

Each source sets a sticky flag. Software clears a flag by writing a zero to its bit. Two independent enable masks are held per source, and each is changed through a write-one-to-set address and a write-one-to-clear address. One mask gates the flags onto a single level-sensitive interrupt line. The other gates one-cycle event pulses that go out to other hardware.

Software reaches the block through a plain synchronous port. Writes take effect on the clock edge, and reads are decoded combinationally from the address. Counting is started, stopped and zeroed by writing to task addresses.

Top module: `slowtick_timer`

## Requirements
- R1: After reset the counter is stopped and reads 0, and all flags and both enable masks are 0. The interrupt line is low and no event pulse is driven.
- R2: The prescaler register (address 3, 12 bits wide) holds a value P. While the counter runs, it advances by one every P+1 clock cycles.
- R3: A write to the prescaler while the counter is running is ignored, and both the stored value and the tick rate stay unchanged.
- R4: Writing 1 in bit 0 of address 0 starts counting, and writing 1 in bit 0 of address 1 stops it. A stopped counter keeps its value, which is readable at address 4.
- R5: Writing 1 in bit 0 of address 2 sets the counter to zero.
- R6: When a tick takes the counter from all ones to zero, the overflow source fires (source bit 1).
- R7: Compare channel i (match value at address 12+i) fires as source bit 2+i when a tick makes the counter equal to its value. Channel 3 exists only when HAS_CMP3 is set.
- R8: The interrupt enable mask is set through address 5 and cleared through address 6. The event enable mask is set through address 7 and cleared through address 8. A write changes only the bits written as 1, and either address reads back its mask. The source bits are tick 0, overflow 1, and compare 2 to 5.
- R9: The flags at address 9 are sticky. Writing 0 to a bit clears that flag, and writing 1 leaves it unchanged, so a 1 never sets a flag. If a source fires in the same cycle as the clearing write, the flag stays set.
- R10: The interrupt output is high exactly while some flag is set and also enabled in the interrupt mask.
- R11: An event output bit pulses high for one cycle, starting the cycle after its source fires. It pulses only if the event mask enables that bit, and the interrupt mask has no effect on it.
- R12: When a clear task coincides with a tick, the clear wins. The counter goes to zero, and no tick, overflow or compare source fires for that cycle.
- R13: The tick source (bit 0) fires on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr |
| irq | output | 1 | Level interrupt |
| evtOut | output | 6 | Per-source event pulses, bit map as in R8 |

## Verification
Two functions can collide in one cycle: a software clear task and a counter tick. The collision matters when that tick would otherwise hit a compare value or wrap the counter. The bench runs the prescaler at zero so every cycle ticks. It waits until the counter sits one below a compare value, or at all ones, and issues the clear in exactly that cycle. It then judges that the counter is zero, that no event pulse appears, and that neither the compare flag nor the overflow flag is set.

// File: rtl/slowtick_pkg.sv
package slowtick_pkg;

  localparam int SRC_W   = 6;
  localparam int MAX_CMP = 4;

  localparam logic [3:0] A_START    = 4'd0;
  localparam logic [3:0] A_STOP     = 4'd1;
  localparam logic [3:0] A_CLEAR    = 4'd2;
  localparam logic [3:0] A_PRESCALE = 4'd3;
  localparam logic [3:0] A_COUNT    = 4'd4;
  localparam logic [3:0] A_IRQ_SET  = 4'd5;
  localparam logic [3:0] A_IRQ_CLR  = 4'd6;
  localparam logic [3:0] A_EVT_SET  = 4'd7;
  localparam logic [3:0] A_EVT_CLR  = 4'd8;
  localparam logic [3:0] A_FLAGS    = 4'd9;
  localparam logic [3:0] A_CMP0     = 4'd12;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic clr;
    logic preLoad;
  } dpCtl_t;

endpackage

// File: rtl/slowtick_dp.sv
module slowtick_dp
  import slowtick_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int PRE_W = 12,
  parameter int NCMP  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtl_t                     ctl,
  input  logic [PRE_W-1:0]           preVal,
  input  logic [NCMP-1:0][CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0]           count,
  output logic [SRC_W-1:0]           srcEv
);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] nextCount;
  logic             preWrap;
  logic             tick;

  assign preWrap   = (preCnt == preVal);
  assign tick      = ctl.run && !ctl.clr && preWrap;
  assign nextCount = count + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      count  <= '0;
    end else if (ctl.clr) begin
      preCnt <= '0;
      count  <= '0;
    end else if (ctl.preLoad) begin
      preCnt <= '0;
    end else if (ctl.run) begin
      if (preWrap) begin
        preCnt <= '0;
        count  <= nextCount;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign srcEv[0] = tick;
  assign srcEv[1] = tick && (&count);

  for (genvar i = 0; i < MAX_CMP; i++) begin : g_cmp
    if (i < NCMP) begin : g_on
      assign srcEv[2+i] = tick && (nextCount == cmpVal[i]);
    end else begin : g_off
      assign srcEv[2+i] = 1'b0;
    end
  end

endmodule

// File: rtl/slowtick_ctrl.sv
module slowtick_ctrl
  import slowtick_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int PRE_W    = 12,
  parameter int NCMP     = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [3:0]                 addr,
  input  logic [31:0]                wrData,
  input  logic [CNT_W-1:0]           count,
  input  logic [SRC_W-1:0]           srcEv,
  output dpCtl_t                     ctl,
  output logic [PRE_W-1:0]           preVal,
  output logic [NCMP-1:0][CNT_W-1:0] cmpVal,
  output logic                       running,
  output logic [SRC_W-1:0]           irqEn,
  output logic [SRC_W-1:0]           evtEn,
  output logic [SRC_W-1:0]           flags,
  output logic [31:0]                rdData,
  output logic                       irq,
  output logic [SRC_W-1:0]           evtOut
);

  localparam logic [SRC_W-1:0] SRC_MASK = SRC_W'((1 << (2 + NCMP)) - 1);

  logic             wrStart, wrStop;
  logic [SRC_W-1:0] wrBits, flagClr;

  assign wrBits  = wrData[SRC_W-1:0] & SRC_MASK;
  assign wrStart = wrEn && (addr == A_START) && wrData[0];
  assign wrStop  = wrEn && (addr == A_STOP)  && wrData[0];
  assign flagClr = (wrEn && addr == A_FLAGS) ? ~wrData[SRC_W-1:0] : '0;

  assign ctl.run     = running;
  assign ctl.clr     = wrEn && (addr == A_CLEAR) && wrData[0];
  assign ctl.preLoad = wrEn && (addr == A_PRESCALE) && !running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      preVal  <= '0;
      irqEn   <= '0;
      evtEn   <= '0;
      flags   <= '0;
      evtOut  <= '0;
    end else begin
      if (wrStart)     running <= 1'b1;
      else if (wrStop) running <= 1'b0;
      if (ctl.preLoad) preVal <= wrData[PRE_W-1:0];
      if (wrEn && addr == A_IRQ_SET) irqEn <= irqEn | wrBits;
      if (wrEn && addr == A_IRQ_CLR) irqEn <= irqEn & ~wrBits;
      if (wrEn && addr == A_EVT_SET) evtEn <= evtEn | wrBits;
      if (wrEn && addr == A_EVT_CLR) evtEn <= evtEn & ~wrBits;
      // a firing source beats a clearing write
      flags  <= ((flags & ~flagClr) | srcEv) & SRC_MASK;
      evtOut <= srcEv & evtEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpVal <= '0;
    end else begin
      for (int i = 0; i < NCMP; i++) begin
        if (wrEn && addr == 4'(A_CMP0 + i)) cmpVal[i] <= wrData[CNT_W-1:0];
      end
    end
  end

  assign irq = |(flags & irqEn);

  always_comb begin
    rdData = '0;
    case (addr)
      A_PRESCALE:           rdData[PRE_W-1:0] = preVal;
      A_COUNT:              rdData[CNT_W-1:0] = count;
      A_IRQ_SET, A_IRQ_CLR: rdData[SRC_W-1:0] = irqEn;
      A_EVT_SET, A_EVT_CLR: rdData[SRC_W-1:0] = evtEn;
      A_FLAGS:              rdData[SRC_W-1:0] = flags;
      default: begin
        for (int i = 0; i < NCMP; i++) begin
          if (addr == 4'(A_CMP0 + i)) rdData[CNT_W-1:0] = cmpVal[i];
        end
      end
    endcase
  end

endmodule

// File: rtl/slowtick_timer.sv
module slowtick_timer
  import slowtick_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int PRE_W    = 12,
  parameter bit HAS_CMP3 = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        irq,
  output logic [5:0]  evtOut
);

  localparam int NCMP = HAS_CMP3 ? MAX_CMP : MAX_CMP - 1;

  dpCtl_t                     ctlStb;
  logic [PRE_W-1:0]           preVal;
  logic [NCMP-1:0][CNT_W-1:0] cmpVal;
  logic [CNT_W-1:0]           count;
  logic [SRC_W-1:0]           srcEv;
  logic                       running;
  logic [SRC_W-1:0]           irqEn, evtEn, flags;

  slowtick_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W), .NCMP(NCMP)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .count(count), .srcEv(srcEv), .ctl(ctlStb), .preVal(preVal),
    .cmpVal(cmpVal), .running(running), .irqEn(irqEn), .evtEn(evtEn),
    .flags(flags), .rdData(rdData), .irq(irq), .evtOut(evtOut)
  );

  slowtick_dp #(.CNT_W(CNT_W), .PRE_W(PRE_W), .NCMP(NCMP)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctlStb), .preVal(preVal),
    .cmpVal(cmpVal), .count(count), .srcEv(srcEv)
  );

endmodule

// File: rtl/slowtick_chk.sv
module slowtick_chk #(
  parameter int CNT_W = 24,
  parameter int PRE_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [3:0]       addr,
  input logic             running,
  input logic             clr,
  input logic [CNT_W-1:0] count,
  input logic [PRE_W-1:0] preVal,
  input logic [5:0]       irqEn,
  input logic [5:0]       evtEn,
  input logic             irq,
  input logic [5:0]       evtOut
);

  a_r3_pre_locked: assert property (@(posedge clk) disable iff (!rstN)
    (running && wrEn && addr == 4'd3) |=> $stable(preVal));

  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !clr) |=> $stable(count));

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (count == '0));

  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    evtOut[1] |-> (count == '0));

  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn == '0) |-> !irq);

  a_r11_evt_gated: assert property (@(posedge clk) disable iff (!rstN)
    (evtOut & ~$past(evtEn)) == '0);

  a_r12_clear_silent: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (evtOut == '0));

endmodule

bind slowtick_timer slowtick_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .running(running),
  .clr(ctlStb.clr), .count(count), .preVal(preVal), .irqEn(irqEn),
  .evtEn(evtEn), .irq(irq), .evtOut(evtOut)
);

// File: tb/sim_slowtick_timer.sv
`timescale 1ns/1ps
module sim_slowtick_timer;

  localparam int CNT_W = 8;
  localparam int ALLONES = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [3:0]  addr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        irq;
  logic [5:0]  evtOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  slowtick_timer #(.CNT_W(CNT_W), .PRE_W(12), .HAS_CMP3(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq), .evtOut(evtOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic waitCount(input int v);
    logic [31:0] c;
    rd(4'd4, c);
    while (c != 32'(v)) begin
      @(negedge clk);
      rd(4'd4, c);
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    rd(4'd4, d); check("R1 count", d, 0);
    rd(4'd9, d); check("R1 flags", d, 0);
    rd(4'd5, d); check("R1 irqEn", d, 0);
    rd(4'd7, d); check("R1 evtEn", d, 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 evtOut", 32'(evtOut), 0);
    repeat (3) @(negedge clk);
    rd(4'd4, d); check("R1 stays stopped", d, 0);
  endtask

  task automatic testPrescale();
    logic [31:0] d, held;
    wr(4'd3, 32'd3);
    rd(4'd3, d); check("R2 prescaler readback", d, 3);
    wr(4'd0, 32'd1);
    repeat (20) @(negedge clk);
    rd(4'd4, d); check("R2 count after 20 cycles at P=3", d, 5);
    wr(4'd3, 32'd0);
    rd(4'd3, d); check("R3 prescaler kept", d, 3);
    repeat (3) @(negedge clk);
    rd(4'd4, d); check("R3 rate kept", d, 6);
    wr(4'd1, 32'd1);
    rd(4'd4, held);
    repeat (10) @(negedge clk);
    rd(4'd4, d); check("R4 stopped count held", d, held);
    wr(4'd2, 32'd1);
    rd(4'd4, d); check("R5 clear to zero", d, 0);
  endtask

  task automatic testCompare();
    logic [31:0] d;
    wr(4'd3, 32'd0);
    wr(4'd7, 32'h3F);
    wr(4'd12, 32'd5);
    wr(4'd15, 32'd9);
    wr(4'd9, 32'd0);
    wr(4'd0, 32'd1);
    waitCount(5);
    check("R7 cmp0 pulse", 32'(evtOut[2]), 1);
    check("R13 tick pulse", 32'(evtOut[0]), 1);
    rd(4'd9, d); check("R7 cmp0 flag", 32'(d[2]), 1);
    @(negedge clk);
    check("R11 pulse one cycle", 32'(evtOut[2]), 0);
    waitCount(9);
    check("R7 cmp3 pulse", 32'(evtOut[5]), 1);
    wr(4'd1, 32'd1);
    rd(4'd9, d); check("R13 R7 flags", d, 32'h25);
  endtask

  task automatic testEnables();
    logic [31:0] d;
    wr(4'd5, 32'h04);
    check("R10 irq on enabled flag", 32'(irq), 1);
    wr(4'd5, 32'h01);
    rd(4'd5, d); check("R8 set keeps other bits", d, 32'h05);
    wr(4'd6, 32'h04);
    rd(4'd6, d); check("R8 clear keeps other bits", d, 32'h01);
    check("R10 irq from tick flag", 32'(irq), 1);
    wr(4'd9, 32'h3E);
    rd(4'd9, d); check("R9 zero bit clears one flag", d, 32'h24);
    check("R10 irq drops", 32'(irq), 0);
    wr(4'd9, 32'h3F);
    rd(4'd9, d); check("R9 ones do not set", d, 32'h24);
  endtask

  task automatic testEvtIndependent();
    logic [31:0] d;
    wr(4'd8, 32'h04);
    rd(4'd7, d); check("R8 event mask clear", d, 32'h3B);
    wr(4'd6, 32'h3F);
    wr(4'd5, 32'h04);
    wr(4'd9, 32'd0);
    wr(4'd2, 32'd1);
    wr(4'd0, 32'd1);
    waitCount(4);
    check("R10 irq low before match", 32'(irq), 0);
    @(negedge clk);
    check("R11 masked event silent", 32'(evtOut[2]), 0);
    check("R11 tick pulse still out", 32'(evtOut[0]), 1);
    check("R10 irq follows masked-event flag", 32'(irq), 1);
    wr(4'd1, 32'd1);
  endtask

  task automatic testOverflow();
    logic [31:0] d;
    wr(4'd7, 32'h3F);
    wr(4'd9, 32'd0);
    wr(4'd2, 32'd1);
    wr(4'd0, 32'd1);
    waitCount(ALLONES);
    @(negedge clk);
    rd(4'd4, d); check("R6 wrap to zero", d, 0);
    check("R6 overflow pulse", 32'(evtOut[1]), 1);
    rd(4'd9, d); check("R6 overflow flag", 32'(d[1]), 1);
    wr(4'd1, 32'd1);
  endtask

  task automatic testClearWins();
    logic [31:0] d;
    wr(4'd9, 32'd0);
    wr(4'd13, 32'd20);
    wr(4'd2, 32'd1);
    wr(4'd0, 32'd1);
    waitCount(19);
    wr(4'd2, 32'd1);
    rd(4'd4, d); check("R12 clear beats tick", d, 0);
    check("R12 no pulses", 32'(evtOut), 0);
    rd(4'd9, d); check("R12 no cmp1 flag", 32'(d[3]), 0);
    waitCount(ALLONES);
    wr(4'd2, 32'd1);
    rd(4'd4, d); check("R12 clear at all ones", d, 0);
    check("R12 no overflow pulse", 32'(evtOut[1]), 0);
    rd(4'd9, d); check("R12 no overflow flag", 32'(d[1]), 0);
    wr(4'd1, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPrescale();
    testCompare();
    testEnables();
    testEvtIndependent();
    testOverflow();
    testClearWins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule